// File: doc/BRIEF.md
# DMA Controller Command, Mask and Request Block

This block holds the controller-wide registers of a four-channel DMA engine: the command byte, the per-channel mode bytes, the mask bits, the status byte (terminal-count flags in the low nibble, request flags in the high nibble) and the byte-pointer flip-flop shared with the address and count registers. Software reaches it through a plain register port of eight control offsets (8 to 15); the address and count registers at offsets 0 to 7 live elsewhere, and writes or reads there have no effect here apart from returning 0 on a read.

From the mask and the request flags the block forms an eligibility vector and a one-hot grant to the lowest-numbered eligible channel. Devices raise and drop requests through per-channel hold and release inputs; the transfer datapath reports the end of a block with a per-channel terminal-count pulse. A command value touching any feature other than the controller-disable bit is refused, and controller-disable holds the grant at zero.

Top module: `dmac_ctrl_regs`

## Requirements
- R1: After reset the mask is 4'hF, command, status, byte pointer and every mode byte are 0, and the grant is 0.
- R2: A write to offset 8 loads the command only when the data is 8'h00 or 8'h04; any other value leaves the command unchanged.
- R3: A write to offset 9 selects the channel in data bits 1:0, sets its request flag (status bit channel+4) when data bit 2 is 1 and clears it otherwise, and clears its terminal-count flag (status bit channel); this write beats a same-cycle hold, release or terminal-count pulse on that channel.
- R4: A write to offset 10 sets mask bit data[1:0] when data bit 2 is 1 and clears it when bit 2 is 0.
- R5: A write to offset 11 stores the whole data byte as the mode byte of channel data[1:0], output on mode_q bits 8*ch+7:8*ch; other channels keep theirs.
- R6: A write to offset 12 clears the byte pointer; byte_ptr_flip otherwise inverts it. A write to offset 13 sets the byte pointer 0, mask 4'hF, status 0 and command 0, leaving mode bytes, and beats every same-cycle input.
- R7: A write to offset 14 clears all mask bits; a write to offset 15 loads the mask from data bits 3:0.
- R8: A read returns its data on reg_rdata in the next cycle: status for offset 8, {4'h0, mask} for offset 15, 0 for any other offset, and 0 in cycles after no read. A status read clears the terminal-count nibble, except for bits set by a same-cycle terminal-count pulse.
- R9: Channel ch is eligible when its mask bit is 0 and its request flag is 1.
- R10: The grant is one-hot on the lowest eligible channel, and 0 when nothing is eligible or command bit 2 is 1.
- R11: A hold input bit sets that channel's request flag, a release input bit clears it, and hold wins when both are high.
- R12: A terminal-count pulse bit sets that channel's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after reg_rd |
| dreq_hold | input | 4 | Per-channel request raise |
| dreq_rel | input | 4 | Per-channel request drop |
| tc_pulse | input | 4 | Per-channel terminal-count pulse |
| byte_ptr_flip | input | 1 | Toggle byte pointer (from address/count registers) |
| byte_ptr | output | 1 | Byte-pointer flip-flop |
| cmd_q | output | 8 | Command byte |
| mask_q | output | 4 | Channel mask bits |
| status_q | output | 8 | Status byte: requests 7:4, terminal counts 3:0 |
| mode_q | output | 32 | Mode bytes, channel 0 in bits 7:0 |
| eligible | output | 4 | Channels eligible for service |
| grant | output | 4 | One-hot service grant |

## Verification
Every cycle the assertions hold the grant to at most one bit, inside the eligible set, on its lowest member and silenced by controller-disable; they also check master reset, refusal of unsupported commands, the read-clear of the terminal-count nibble, idle read data and request hold. Which of several colliding sources wins a status bit, mode storage per channel, the byte-pointer toggling and the exact read values are shown only by the bench's directed and random scenarios against its reference model.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam logic [3:0] OFF_CMD    = 4'h8;
  localparam logic [3:0] OFF_REQ    = 4'h9;
  localparam logic [3:0] OFF_SMASK  = 4'hA;
  localparam logic [3:0] OFF_MODE   = 4'hB;
  localparam logic [3:0] OFF_FFCLR  = 4'hC;
  localparam logic [3:0] OFF_MRESET = 4'hD;
  localparam logic [3:0] OFF_MCLR   = 4'hE;
  localparam logic [3:0] OFF_MLOAD  = 4'hF;

  // command bits that may be set; any other bit makes the write void
  localparam logic [7:0] CMD_ALLOWED = 8'h04;
  localparam int         CMD_DISABLE_BIT = 2;

  typedef struct packed {
    logic cmd;
    logic req;
    logic smask;
    logic mode;
    logic ffclr;
    logic mreset;
    logic mclr;
    logic mload;
  } wr_dec_t;
endpackage

// File: rtl/dmac_ctrl_decode.sv
module dmac_ctrl_decode
  import dmac_pkg::*;
(
  input  logic       wr,
  input  logic [3:0] off,
  output wr_dec_t    dec
);
  always_comb begin
    dec = '0;
    if (wr) begin
      unique case (off)
        OFF_CMD:    dec.cmd    = 1'b1;
        OFF_REQ:    dec.req    = 1'b1;
        OFF_SMASK:  dec.smask  = 1'b1;
        OFF_MODE:   dec.mode   = 1'b1;
        OFF_FFCLR:  dec.ffclr  = 1'b1;
        OFF_MRESET: dec.mreset = 1'b1;
        OFF_MCLR:   dec.mclr   = 1'b1;
        OFF_MLOAD:  dec.mload  = 1'b1;
        default:    dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/dmac_status_reg.sv
module dmac_status_reg #(
  parameter int NCH  = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mreset,
  input  logic            req_wr,
  input  logic [CH_W-1:0] req_ch,
  input  logic            req_set,
  input  logic            rd_clr,
  input  logic [NCH-1:0]  hold,
  input  logic [NCH-1:0]  rel,
  input  logic [NCH-1:0]  tc,
  output logic [NCH-1:0]  req_q,
  output logic [NCH-1:0]  tc_q
);
  logic [NCH-1:0] req_n, tc_n;

  always_comb begin
    req_n = (req_q & ~rel) | hold;
    tc_n  = (rd_clr ? '0 : tc_q) | tc;
    if (req_wr) begin
      req_n[req_ch] = req_set;
      tc_n[req_ch]  = 1'b0;
    end
    if (mreset) begin
      req_n = '0;
      tc_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      tc_q  <= '0;
    end else begin
      req_q <= req_n;
      tc_q  <= tc_n;
    end
  end
endmodule

// File: rtl/dmac_mode_bank.sv
module dmac_mode_bank #(
  parameter int NCH  = 4,
  parameter int DW   = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [DW-1:0]     wdata,
  output logic [NCH*DW-1:0] mode_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mode_q[c*DW +: DW] <= '0;
      else if (mode_wr && (wdata[CH_W-1:0] == CH_W'(c)))
        mode_q[c*DW +: DW] <= wdata;
    end
  end
endmodule

// File: rtl/dmac_grant_arb.sv
module dmac_grant_arb #(
  parameter int NCH = 4
) (
  input  logic           enable,
  input  logic [NCH-1:0] elig,
  output logic [NCH-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
    if (!enable) gnt = '0;
  end
endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_off,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NCH-1:0]    dreq_hold,
  input  logic [NCH-1:0]    dreq_rel,
  input  logic [NCH-1:0]    tc_pulse,
  input  logic              byte_ptr_flip,
  output logic              byte_ptr,
  output logic [DW-1:0]     cmd_q,
  output logic [NCH-1:0]    mask_q,
  output logic [DW-1:0]     status_q,
  output logic [NCH*DW-1:0] mode_q,
  output logic [NCH-1:0]    eligible,
  output logic [NCH-1:0]    grant
);
  wr_dec_t        dec;
  logic [NCH-1:0] req_q, tc_q;
  logic           stat_rd;
  logic [DW-1:0]  rd_mux;
  logic [DW-1:0]  mask_rd;

  dmac_ctrl_decode u_dec (.wr(reg_wr), .off(reg_off), .dec(dec));

  assign stat_rd = reg_rd && (reg_off == OFF_CMD);

  dmac_status_reg #(.NCH(NCH)) u_stat (
    .clk(clk), .rst_n(rst_n), .mreset(dec.mreset),
    .req_wr(dec.req), .req_ch(reg_wdata[CH_W-1:0]), .req_set(reg_wdata[CH_W]),
    .rd_clr(stat_rd), .hold(dreq_hold), .rel(dreq_rel), .tc(tc_pulse),
    .req_q(req_q), .tc_q(tc_q)
  );

  dmac_mode_bank #(.NCH(NCH), .DW(DW)) u_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr(dec.mode), .wdata(reg_wdata), .mode_q(mode_q)
  );

  always_comb begin
    status_q = '0;
    status_q[2*NCH-1:0] = {req_q, tc_q};
    mask_rd = '0;
    mask_rd[NCH-1:0] = mask_q;
  end

  // command register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmd_q <= '0;
    else if (dec.mreset)
      cmd_q <= '0;
    else if (dec.cmd && ((reg_wdata & ~DW'(CMD_ALLOWED)) == '0))
      cmd_q <= reg_wdata;
  end

  // mask register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '1;
    else if (dec.mreset)
      mask_q <= '1;
    else if (dec.mclr)
      mask_q <= '0;
    else if (dec.mload)
      mask_q <= reg_wdata[NCH-1:0];
    else if (dec.smask)
      mask_q[reg_wdata[CH_W-1:0]] <= reg_wdata[CH_W];
  end

  // byte pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      byte_ptr <= 1'b0;
    else if (dec.ffclr || dec.mreset)
      byte_ptr <= 1'b0;
    else if (byte_ptr_flip)
      byte_ptr <= ~byte_ptr;
  end

  // readback
  always_comb begin
    rd_mux = '0;
    if (reg_rd) begin
      if (reg_off == OFF_CMD)        rd_mux = status_q;
      else if (reg_off == OFF_MLOAD) rd_mux = mask_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_mux;
  end

  assign eligible = ~mask_q & req_q;

  dmac_grant_arb #(.NCH(NCH)) u_arb (
    .enable(!cmd_q[CMD_DISABLE_BIT]), .elig(eligible), .gnt(grant)
  );
endmodule

// File: rtl/dmac_ctrl_sva.sv
module dmac_ctrl_sva #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [3:0]        reg_off,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     reg_rdata,
  input logic [NCH-1:0]    dreq_hold,
  input logic [NCH-1:0]    tc_pulse,
  input logic [DW-1:0]     cmd_q,
  input logic [NCH-1:0]    mask_q,
  input logic [DW-1:0]     status_q,
  input logic [NCH-1:0]    eligible,
  input logic [NCH-1:0]    grant
);
  localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_in_elig_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~eligible) == '0);

  assert_grant_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((eligible & (grant - ONE)) == '0));

  assert_grant_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[2] |-> (grant == '0));

  assert_grant_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((eligible != '0) && !cmd_q[2]) |-> (grant != '0));

  assert_master_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_off == 4'hD) |=> (mask_q == '1 && cmd_q == '0 && status_q == '0));

  assert_cmd_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_off == 4'h8 && (reg_wdata & ~DW'(8'h04)) != '0) |=> $stable(cmd_q));

  assert_status_rdclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_off == 4'h8 && !reg_wr && tc_pulse == '0) |=> (status_q[NCH-1:0] == '0));

  assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == '0));

  assert_hold_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ((status_q[2*NCH-1:NCH] & $past(dreq_hold)) == $past(dreq_hold)));
endmodule

bind dmac_ctrl_regs dmac_ctrl_sva #(.NCH(NCH), .DW(DW)) sva_i (.*);

// File: tb/dmac_ctrl_regs_tb_top.sv
module dmac_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_off = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [3:0]  dreq_hold = '0, dreq_rel = '0, tc_pulse = '0;
  logic        byte_ptr_flip = 1'b0;
  logic        byte_ptr;
  logic [7:0]  cmd_q, status_q;
  logic [3:0]  mask_q, eligible, grant;
  logic [31:0] mode_q;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  dmac_ctrl_regs dut_i (.*);

  // behavioural reference model
  int m_cmd, m_mask, m_req, m_tc, m_ff, m_rd;
  int m_mode[4];

  always @(posedge clk) begin
    int ch;
    int rd_v;
    if (!rst_n) begin
      m_cmd = 0; m_mask = 15; m_req = 0; m_tc = 0; m_ff = 0; m_rd = 0;
      foreach (m_mode[i]) m_mode[i] = 0;
    end else begin
      rd_v = 0;
      if (reg_rd && reg_off == 8)  rd_v = m_req * 16 + m_tc;
      if (reg_rd && reg_off == 15) rd_v = m_mask;
      m_req = (m_req & ~int'(dreq_rel)) | int'(dreq_hold);
      if (reg_rd && reg_off == 8) m_tc = 0;
      m_tc = m_tc | int'(tc_pulse);
      if (byte_ptr_flip) m_ff = 1 - m_ff;
      ch = int'(reg_wdata[1:0]);
      if (reg_wr) begin
        case (int'(reg_off))
          8:  if (reg_wdata == 8'h00 || reg_wdata == 8'h04) m_cmd = int'(reg_wdata);
          9:  begin
                if (reg_wdata[2]) m_req = m_req | (1 << ch);
                else              m_req = m_req & ~(1 << ch);
                m_tc = m_tc & ~(1 << ch);
              end
          10: if (reg_wdata[2]) m_mask = m_mask | (1 << ch);
              else              m_mask = m_mask & ~(1 << ch);
          11: m_mode[ch] = int'(reg_wdata);
          12: m_ff = 0;
          13: begin m_ff = 0; m_mask = 15; m_req = 0; m_tc = 0; m_cmd = 0; end
          14: m_mask = 0;
          15: m_mask = int'(reg_wdata[3:0]);
          default: ;
        endcase
      end
      m_rd = rd_v;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_grant();
    int e = ~m_mask & m_req & 15;
    if (m_cmd & 4) return 0;
    for (int i = 0; i < 4; i++) if (e & (1 << i)) return 1 << i;
    return 0;
  endfunction

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "cmd_q", int'(cmd_q), m_cmd);
      chk("R7", "mask_q", int'(mask_q), m_mask);
      chk("R3", "status_q", int'(status_q), m_req * 16 + m_tc);
      chk("R6", "byte_ptr", int'(byte_ptr), m_ff);
      chk("R5", "mode_q", int'(mode_q),
          (m_mode[3] << 24) | (m_mode[2] << 16) | (m_mode[1] << 8) | m_mode[0]);
      chk("R8", "reg_rdata", int'(reg_rdata), m_rd);
      chk("R9", "eligible", int'(eligible), ~m_mask & m_req & 15);
      chk("R10", "grant", int'(grant), exp_grant());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int off, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = 4'(off); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int off);
    @(negedge clk);
    reg_rd = 1'b1; reg_off = 4'(off);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "mask", int'(mask_q), 15);
    chk("R1", "cmd", int'(cmd_q), 0);
    chk("R1", "status", int'(status_q), 0);
    chk("R1", "grant", int'(grant), 0);
    chk("R1", "mode", int'(mode_q), 0);
    // R7 clear and load
    wr(14, 0);      chk("R7", "mask clear", int'(mask_q), 0);
    wr(15, 8'hF5);  chk("R7", "mask load", int'(mask_q), 5);
    wr(14, 0);
    // R4 single mask
    wr(10, 8'h06);  chk("R4", "mask set ch2", int'(mask_q), 4);
    wr(10, 8'h02);  chk("R4", "mask clear ch2", int'(mask_q), 0);
    // R11 hold/release, R9/R10 grant
    @(negedge clk); dreq_hold = 4'b1010;
    @(negedge clk); dreq_hold = 4'b0000;
    chk("R11", "req set", int'(status_q), 8'hA0);
    chk("R10", "lowest grant", int'(grant), 2);
    @(negedge clk); dreq_rel = 4'b0010; dreq_hold = 4'b0010;
    @(negedge clk); dreq_rel = 4'b0000; dreq_hold = 4'b0000;
    chk("R11", "hold beats release", int'(status_q), 8'hA0);
    @(negedge clk); dreq_rel = 4'b0010;
    @(negedge clk); dreq_rel = 4'b0000;
    chk("R11", "req cleared", int'(status_q), 8'h80);
    chk("R10", "grant moves", int'(grant), 8);
    // R2 command accept/reject
    wr(8, 8'h05);   chk("R2", "reject", int'(cmd_q), 0);
    wr(8, 8'h04);   chk("R2", "accept", int'(cmd_q), 4);
    chk("R10", "disabled", int'(grant), 0);
    wr(8, 8'h00);   chk("R2", "zero", int'(cmd_q), 0);
    // R12 terminal count, R8 read-clear
    @(negedge clk); tc_pulse = 4'b1001;
    @(negedge clk); tc_pulse = 4'b0000;
    chk("R12", "tc set", int'(status_q), 8'h89);
    rd(8);          chk("R8", "status read", int'(reg_rdata), 8'h89);
    chk("R8", "tc cleared", int'(status_q), 8'h80);
    // R3 request write clears tc on channel
    @(negedge clk); tc_pulse = 4'b0010;
    @(negedge clk); tc_pulse = 4'b0000;
    wr(9, 8'h05);   chk("R3", "req write", int'(status_q), 8'hA0);
    wr(9, 8'h03);   chk("R3", "req clear", int'(status_q), 8'h20);
    // R5 mode
    wr(11, 8'h4A);  chk("R5", "mode ch2", int'(mode_q), 32'h004A_0000);
    // R6 byte pointer and master reset
    @(negedge clk); byte_ptr_flip = 1'b1;
    @(negedge clk); byte_ptr_flip = 1'b0;
    chk("R6", "flip", int'(byte_ptr), 1);
    wr(12, 0);      chk("R6", "ff clear", int'(byte_ptr), 0);
    wr(13, 0);      chk("R6", "mreset mask", int'(mask_q), 15);
    chk("R6", "mreset status", int'(status_q), 0);
    chk("R6", "mode kept", int'(mode_q), 32'h004A_0000);
    rd(15);         chk("R8", "mask read", int'(reg_rdata), 15);
    rd(3);          chk("R8", "other read", int'(reg_rdata), 0);
    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      reg_wr = ($urandom_range(0, 2) == 0);
      reg_rd = ($urandom_range(0, 3) == 0);
      reg_off = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 7))
                                             : 4'($urandom_range(8, 15));
      if (reg_off == 4'hD && $urandom_range(0, 3) != 0) reg_off = 4'hA;
      reg_wdata = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 7))
                                               : 8'($urandom_range(0, 255));
      dreq_hold = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      dreq_rel = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      tc_pulse = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      byte_ptr_flip = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; dreq_hold = 0; dreq_rel = 0; tc_pulse = 0; byte_ptr_flip = 0;
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule